// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

A bank of independent down-counting timer channels clocked by the fast bus clock and controlled through a flat register interface: address, write enable, read strobe, write data and combinational read data. The number of channels is a parameter and may be 2 or 4. Each channel holds a 64-bit interval and a 64-bit live count, both split into 32-bit low and high words. It has a 3-bit prescaler and runs either in periodic-reload mode or in one-shot mode.

Software writes the interval and then sets the enable and reload bits together. On the first prescaled tick the count takes the interval value. Each later tick lowers it by one. The tick that brings the count from 1 to 0 is an expiry, and each expiry sets the channel's pending flag in a shared status register. Each channel has its own interrupt line, which is high while that channel's flag is pending and its bit in the shared enable register is set. After a disable, the channel goes on counting for a short fixed drain before it freezes, so any tick already in flight completes.

Top module: `hst_timer_bank`

## Requirements
- R1: After reset every register reads 0 and every interrupt output is low.
- R2: Register map:
  - Interrupt enable is at 0x00 and interrupt status is at 0x04.
  - Channel n uses 0x20*n+0x10 (control), +0x14 and +0x18 (interval low and high) and +0x1C and +0x20 (count low and high).
  - The interval words read back as written.
  - Writes to the count words are ignored.
  - Unmapped addresses read 0.
- R3: Control fields:
  - Bit 0 is enable.
  - Bit 1 is the reload request. It reads 1 while pending, even with the channel disabled. It reads 0 once the first tick of an enabled channel has copied the interval into the count.
  - Bits 6:4 are the prescaler select.
  - Bit 7 selects one-shot mode when set and periodic mode when clear.
- R4: While a channel runs it ticks once every 2^psc clock cycles. The first tick falls 2^psc cycles after the enabling write, so with psc 0 the loaded interval is visible one cycle after that write.
- R5: Each tick after the load lowers the count by one. The tick that takes the count from 1 to 0 sets the channel's status bit.
- R6: In periodic mode the tick after the count reaches 0 reloads the current interval, giving a period of interval+1 ticks.
- R7: In one-shot mode the count stays at 0 after expiry, and no further expiry occurs until a new reload.
- R8: After a write clears the enable bit, the channel still counts on that write's edge and on the next 2 edges, then freezes. A stopped channel's count never changes.
- R9: Writing an interval word alone does not change a running count. The new value is used at the next reload.
- R10: The status register is write-one-to-clear: a 1 in bit n clears channel n's flag and a 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R11: irq_o[n] is high exactly when status bit n and enable bit n are both set.
- R12: A read of a count low word (read strobe high) captures the high word. A later read of the count high word returns that captured value, so a 64-bit read is coherent.
- R13: Channels are independent: activity on one never changes another's count or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, also the timer source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| re_i | input | 1 | Read strobe; used only to capture the count high word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | N_CH | Per-channel interrupt request |

## Verification
The checker runs on every cycle and covers:
- an expiry always sets the status flag;
- a write-one clear drops the flag unless an expiry coincides with it;
- a stopped channel's count never moves;
- a one-shot count parked at 0 stays there;
- an interrupt rises only after an expiry or a write to the enable register.

Only the bench's scenarios can show the exact timing. This covers:
- the cycle of the first tick and the period under each prescaler setting;
- the periodic period and the one-shot hold, with their expected values;
- the length of the disable drain;
- the coherent high word while the count crosses a 32-bit boundary;
- the register map itself.

// File: rtl/hst_pkg.sv
`timescale 1ns/1ps
package hst_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 2 * DATA_W;
  localparam int PSC_W     = 3;
  localparam int STOP_DLY  = 2;

  localparam int OFF_IE    = 'h00;
  localparam int OFF_ST    = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h20;

  localparam int REG_CTL   = 'h00;
  localparam int REG_ILO   = 'h04;
  localparam int REG_IHI   = 'h08;
  localparam int REG_CLO   = 'h0C;
  localparam int REG_CHI   = 'h10;

  localparam int CTL_EN      = 0;
  localparam int CTL_RLD     = 1;
  localparam int CTL_PSC_LSB = 4;
  localparam int CTL_OS      = 7;

  typedef struct packed {
    logic             os;
    logic [PSC_W-1:0] psc;
    logic             en;
  } ctl_t;
endpackage

// File: rtl/hst_prescaler.sv
`timescale 1ns/1ps
module hst_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << sel_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  // divider restarts from zero whenever the channel is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
    else            div_q <= '0;
  end
endmodule

// File: rtl/hst_channel.sv
`timescale 1ns/1ps
module hst_channel
  import hst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              ilo_we_i,
  input  logic              ihi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [CNT_W-1:0]  ival_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o,
  output logic              tick_o,
  output logic              expire_o,
  output logic              oneshot_o,
  output logic              reload_o
);
  localparam int STOP_W = $clog2(STOP_DLY + 1);

  ctl_t              ctl_q;
  logic              rld_q;
  logic [STOP_W-1:0] stop_q;
  logic [CNT_W-1:0]  ival_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active;
  logic              tick;

  assign active = ctl_q.en || (stop_q != '0);

  hst_prescaler #(.SEL_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .sel_i  (ctl_q.psc),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (ctl_we_i)
      ctl_q <= '{os:  wdata_i[CTL_OS],
                 psc: wdata_i[CTL_PSC_LSB +: PSC_W],
                 en:  wdata_i[CTL_EN]};
  end

  // reload request waits for the next tick of a running channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rld_q <= 1'b0;
    else if (ctl_we_i && wdata_i[CTL_RLD]) rld_q <= 1'b1;
    else if (tick)                        rld_q <= 1'b0;
  end

  // disable drain: keep counting for STOP_DLY more edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   stop_q <= '0;
    else if (ctl_we_i && !wdata_i[CTL_EN] && ctl_q.en) stop_q <= STOP_W'(STOP_DLY);
    else if (stop_q != '0)                         stop_q <= stop_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ival_q <= '0;
    else begin
      if (ilo_we_i) ival_q[DATA_W-1:0]     <= wdata_i;
      if (ihi_we_i) ival_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) begin
      if (rld_q)              cnt_q <= ival_q;
      else if (cnt_q == '0) begin
        if (!ctl_q.os)        cnt_q <= ival_q;
      end
      else                    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = tick && !rld_q && (cnt_q == CNT_W'(1));

  always_comb begin
    ctl_o                            = '0;
    ctl_o[CTL_EN]                    = ctl_q.en;
    ctl_o[CTL_RLD]                   = rld_q;
    ctl_o[CTL_PSC_LSB +: PSC_W]      = ctl_q.psc;
    ctl_o[CTL_OS]                    = ctl_q.os;
  end

  assign ival_o    = ival_q;
  assign cnt_o     = cnt_q;
  assign active_o  = active;
  assign tick_o    = tick;
  assign oneshot_o = ctl_q.os;
  assign reload_o  = rld_q;
endmodule

// File: rtl/hst_timer_bank.sv
`timescale 1ns/1ps
module hst_timer_bank
  import hst_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  if (N_CH != 2 && N_CH != 4) begin : g_bad_cfg
    $error("hst_timer_bank: N_CH must be 2 or 4");
  end

  function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int off);
    return ADDR_W'(CH_BASE + CH_STRIDE * ch + off);
  endfunction

  logic [N_CH-1:0]             ie_q, st_q, st_clr;
  logic                        ie_wr, st_wr;
  logic [N_CH-1:0]             expire, active, tick, os_bit, rld_bit;
  logic [N_CH-1:0][CNT_W-1:0]  cnt, ival;
  logic [N_CH-1:0][DATA_W-1:0] ctl_rd, hi_q;

  assign ie_wr  = we_i && (addr_i == ADDR_W'(OFF_IE));
  assign st_wr  = we_i && (addr_i == ADDR_W'(OFF_ST));
  assign st_clr = {N_CH{st_wr}} & wdata_i[N_CH-1:0];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    hst_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (we_i && (addr_i == reg_addr(g, REG_CTL))),
      .ilo_we_i  (we_i && (addr_i == reg_addr(g, REG_ILO))),
      .ihi_we_i  (we_i && (addr_i == reg_addr(g, REG_IHI))),
      .wdata_i   (wdata_i),
      .ctl_o     (ctl_rd[g]),
      .ival_o    (ival[g]),
      .cnt_o     (cnt[g]),
      .active_o  (active[g]),
      .tick_o    (tick[g]),
      .expire_o  (expire[g]),
      .oneshot_o (os_bit[g]),
      .reload_o  (rld_bit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ie_q <= '0;
    else if (ie_wr) ie_q <= wdata_i[N_CH-1:0];
  end

  // expiry has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~st_clr) | expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else begin
      for (int n = 0; n < N_CH; n++)
        if (re_i && (addr_i == reg_addr(n, REG_CLO)))
          hi_q[n] <= cnt[n][CNT_W-1:DATA_W];
    end
  end

  assign irq_o = st_q & ie_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_IE)) rdata_o = DATA_W'(ie_q);
    if (addr_i == ADDR_W'(OFF_ST)) rdata_o = DATA_W'(st_q);
    for (int n = 0; n < N_CH; n++) begin
      if (addr_i == reg_addr(n, REG_CTL)) rdata_o = ctl_rd[n];
      if (addr_i == reg_addr(n, REG_ILO)) rdata_o = ival[n][DATA_W-1:0];
      if (addr_i == reg_addr(n, REG_IHI)) rdata_o = ival[n][CNT_W-1:DATA_W];
      if (addr_i == reg_addr(n, REG_CLO)) rdata_o = cnt[n][DATA_W-1:0];
      if (addr_i == reg_addr(n, REG_CHI)) rdata_o = hi_q[n];
    end
  end
endmodule

// File: rtl/hst_timer_bank_chk.sv
`timescale 1ns/1ps
module hst_timer_bank_chk
  import hst_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CH-1:0]            irq_o,
  input logic [N_CH-1:0]            st_q,
  input logic [N_CH-1:0]            st_clr,
  input logic [N_CH-1:0]            ie_q,
  input logic                       ie_wr,
  input logic [N_CH-1:0]            expire,
  input logic [N_CH-1:0]            active,
  input logic [N_CH-1:0]            tick,
  input logic [N_CH-1:0]            os_bit,
  input logic [N_CH-1:0]            rld_bit,
  input logic [N_CH-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    a_r5_expire_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[g] |=> st_q[g]);

    a_r10_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_clr[g] && !expire[g]) |=> !st_q[g]);

    a_r8_idle_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active[g] |=> $stable(cnt[g]));

    a_r7_oneshot_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (os_bit[g] && !rld_bit[g] && (cnt[g] == '0)) |=> (cnt[g] == '0));

    a_r11_irq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> ($past(expire[g]) || $past(ie_wr)));

    a_r4_tick_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick[g] && !ie_q[g]) |-> active[g]);
  end
endmodule

bind hst_timer_bank hst_timer_bank_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/hst_timer_bank_test.sv
`timescale 1ns/1ps
module hst_timer_bank_test;
  localparam int N_CH   = 4;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [2:0]  psc;
    logic        os;
    logic [31:0] ival;
    logic [7:0]  m;
    logic [31:0] exp_cnt;
    logic        exp_st;
  } vec_t;

  // count and status m cycles after an enable+reload write on channel 1
  localparam vec_t VEC [11] = '{
    '{3'd0, 1'b0, 32'd10, 8'd6,  32'd5,  1'b0},
    '{3'd0, 1'b0, 32'd10, 8'd11, 32'd0,  1'b1},
    '{3'd0, 1'b0, 32'd10, 8'd12, 32'd10, 1'b1},
    '{3'd0, 1'b1, 32'd10, 8'd10, 32'd1,  1'b0},
    '{3'd0, 1'b1, 32'd10, 8'd15, 32'd0,  1'b1},
    '{3'd2, 1'b0, 32'd5,  8'd12, 32'd3,  1'b0},
    '{3'd2, 1'b0, 32'd5,  8'd24, 32'd0,  1'b1},
    '{3'd2, 1'b0, 32'd5,  8'd28, 32'd5,  1'b1},
    '{3'd3, 1'b1, 32'd4,  8'd80, 32'd0,  1'b1},
    '{3'd1, 1'b0, 32'd3,  8'd17, 32'd0,  1'b1},
    '{3'd0, 1'b0, 32'd3,  8'd9,  32'd3,  1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic              re = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_CH-1:0]   irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hst_timer_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic rdl(input logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #0.1;
    d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_n(input int m);
    repeat (m) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(8'h00, d); chk("R1 ie", d, 0);
    peek(8'h04, d); chk("R1 status", d, 0);
    peek(8'h10, d); chk("R1 ctl0", d, 0);
    peek(8'h7C, d); chk("R1 cnt3 lo", d, 0);
    peek(8'h80, d); chk("R1 cnt3 hi", d, 0);
    chk("R1 irq", irq, 0);

    // R2 map, read-only count, unmapped
    wr(8'h14, 32'hA5A5_0001); peek(8'h14, d); chk("R2 ival0 lo", d, 32'hA5A5_0001);
    wr(8'h78, 32'h0000_1234); peek(8'h78, d); chk("R2 ival3 hi", d, 32'h1234);
    wr(8'h1C, 32'h55);        peek(8'h1C, d); chk("R2 count read-only", d, 0);
    peek(8'h0C, d); chk("R2 unmapped", d, 0);

    // R3 reload pending without enable, channel 2
    wr(8'h54, 32'd7); wr(8'h58, 32'd0); wr(8'h50, 32'h2);
    wait_n(3);
    peek(8'h50, d); chk("R3 reload pending", d, 32'h2);
    peek(8'h5C, d); chk("R3 no load while disabled", d, 0);
    wr(8'h50, 32'h3);
    wait_n(1);
    peek(8'h50, d); chk("R3 reload consumed", d, 32'h1);
    peek(8'h5C, d); chk("R4 first tick loads", d, 7);

    // R8 disable drain on channel 2
    wr(8'h54, 32'd1000); wr(8'h50, 32'h3);
    wait_n(1);
    peek(8'h5C, d); chk("R8 reload 1000", d, 1000);
    wait_n(9);
    wr(8'h50, 32'h0);
    wait_n(5);
    peek(8'h5C, d); chk("R8 stops after drain", d, 988);
    wait_n(10);
    peek(8'h5C, d); chk("R8 frozen", d, 988);

    // R4 R5 R6 R7 vector table on channel 1
    wr(8'h00, 32'h2);
    for (int i = 0; i < 11; i++) begin
      wr(8'h30, 32'h0);
      wait_n(4);
      wr(8'h04, 32'h2);
      wr(8'h34, VEC[i].ival);
      wr(8'h38, 32'h0);
      wr(8'h30, 32'h3 | (32'(VEC[i].psc) << 4) | (32'(VEC[i].os) << 7));
      wait_n(int'(VEC[i].m));
      peek(8'h3C, d);
      chk($sformatf("R4 R5 R6 R7 vec %0d count", i), d, VEC[i].exp_cnt);
      peek(8'h04, d);
      chk($sformatf("R5 vec %0d status", i), d[1], VEC[i].exp_st);
      chk($sformatf("R11 vec %0d irq", i), irq[1], VEC[i].exp_st);
    end

    // R9 interval write does not restart, channel 3
    wr(8'h78, 32'h0); wr(8'h74, 32'd100); wr(8'h70, 32'h3);
    wait_n(1);
    peek(8'h7C, d); chk("R9 loaded", d, 100);
    wr(8'h74, 32'd5);
    wait_n(3);
    peek(8'h7C, d); chk("R9 count unaffected", d, 96);
    wait_n(97);
    peek(8'h7C, d); chk("R6 reload uses new interval", d, 5);
    peek(8'h04, d); chk("R5 ch3 status", d[3], 1);

    // R10 R11 write-one-to-clear and masking
    wr(8'h70, 32'h0); wr(8'h30, 32'h0);
    wait_n(4);
    peek(8'h04, d); chk("R10 both pending", d & 32'hA, 32'hA);
    wr(8'h04, 32'h0);
    peek(8'h04, d); chk("R10 zero write no effect", d & 32'hA, 32'hA);
    wr(8'h04, 32'h8);
    peek(8'h04, d); chk("R10 clear bit3 only", d & 32'hA, 32'h2);
    chk("R11 irq enabled ch1", irq, 4'b0010);
    wr(8'h00, 32'h0);
    chk("R11 irq masked", irq, 0);
    peek(8'h04, d); chk("R11 status kept when masked", d[1], 1);
    wr(8'h04, 32'hF);
    peek(8'h04, d); chk("R10 clear all", d, 0);

    // R10 expiry wins over same-cycle clear, channel 0
    wr(8'h18, 32'h0); wr(8'h14, 32'd2); wr(8'h10, 32'h3);
    wait_n(2);
    wr(8'h04, 32'h1);
    peek(8'h04, d); chk("R10 expiry beats clear", d[0], 1);
    wr(8'h04, 32'h1);
    peek(8'h04, d); chk("R10 clear after expiry", d[0], 0);
    wr(8'h10, 32'h0);
    wait_n(4);

    // R12 coherent high word, channel 0
    wr(8'h14, 32'd5); wr(8'h18, 32'd1); wr(8'h10, 32'h3);
    wait_n(1);
    rdl(8'h1C, d); chk("R12 low word", d, 5);
    wait_n(20);
    peek(8'h20, d); chk("R12 latched high", d, 1);
    rdl(8'h1C, d);
    peek(8'h20, d); chk("R12 relatched high", d, 0);

    // R13 channel 2 untouched by all other activity
    peek(8'h5C, d); chk("R13 ch2 independent", d, 988);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule